// File: doc/BRIEF.md
# Register Rename Map with Checkpoint Recovery

This block keeps, for every architectural register, a record of whether an instruction still in flight will produce that register's value, and if so which reorder-buffer slot holds or will hold it. The rename stage reads two source registers per cycle to learn where each operand lives. A hit means the operand comes from the reorder buffer slot reported. A miss means the architectural register file holds the committed value. The same stage writes one destination per cycle, which points that register at the reorder-buffer slot just allocated for the instruction. When an instruction retires, the retire stage clears its destination's mapping, but only if no younger instruction has since taken over that register.

Two recovery paths are provided. A flush clears every mapping. It is used once the faulting or mispredicted instruction has reached retirement, when the architectural file is correct for every register. For early recovery, the whole map can be copied into one of several snapshot slots at any instruction that may mispredict. A restore then reloads that slot in a single cycle as soon as the misprediction is found. Register 0 is hardwired and is never mapped.

Top module: `rename_map_table`

## Requirements
- R1: In the first cycle after reset is released, both lookup ports report a miss (hit = 0, tag = 0). Every register is unmapped.
- R2: A lookup presented in cycle t is answered on `lk_*_hit` / `lk_*_tag` after the clock edge that ends cycle t. A hit carries the reorder-buffer tag of the youngest in-flight producer. A miss always carries tag 0.
- R3: A rename (`ren_en`) of register r to tag T is seen by any lookup of r presented in a later cycle, as a hit with tag T.
- R4: A lookup in the same cycle as a rename sees the map as it stood before that rename. An instruction whose source equals its destination therefore reads the older producer.
- R5: A retire (`ret_en`, `ret_reg`, `ret_tag`) clears the mapping of `ret_reg` only when its current tag equals `ret_tag`. If the tag differs, the mapping is left unchanged.
- R6: Register 0 is never mapped. A rename of register 0 has no effect, and a lookup of register 0 always misses.
- R7: A flush (`flush_en`) clears every mapping and every snapshot's mappings. It overrides a restore, a rename and a retire in the same cycle.
- R8: A snapshot (`snap_en`, `snap_slot`) stores the map as it stands after that cycle's update, including a rename made in that same cycle. A restore (`rcv_en`, `rcv_slot`) replaces the whole map with that slot's contents, and the next cycle's lookups see the restored map.
- R9: A restore takes priority over a rename in the same cycle. That rename is dropped.
- R10: A retire also clears matching mappings held in every snapshot slot. A retire in the same cycle as a restore is applied to the restored map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_a_reg | input | REG_W | Source A register to look up |
| lk_a_hit | output | 1 | Source A mapped to an in-flight producer |
| lk_a_tag | output | TAG_W | Source A reorder-buffer tag (0 on miss) |
| lk_b_reg | input | REG_W | Source B register to look up |
| lk_b_hit | output | 1 | Source B mapped to an in-flight producer |
| lk_b_tag | output | TAG_W | Source B reorder-buffer tag (0 on miss) |
| ren_en | input | 1 | Install a destination mapping |
| ren_reg | input | REG_W | Destination register |
| ren_tag | input | TAG_W | Newly allocated reorder-buffer tag |
| ret_en | input | 1 | Retire a destination |
| ret_reg | input | REG_W | Retiring instruction's destination |
| ret_tag | input | TAG_W | Retiring instruction's reorder-buffer tag |
| snap_en | input | 1 | Capture a snapshot |
| snap_slot | input | SLOT_W | Snapshot slot to write |
| rcv_en | input | 1 | Restore the map from a snapshot |
| rcv_slot | input | SLOT_W | Snapshot slot to restore |
| flush_en | input | 1 | Clear every mapping |

## Verification
A corrupted map entry shows up as a wrong hit or tag on the next lookup of that register. This happens one cycle after the lookup is presented, so a bad update is visible two edges after the stimulus that caused it. A snapshot that is stale or was missed stays hidden until a restore of that slot, and then it shows on every lookup that follows. For this reason the stimulus mixes restores of long-held slots with retires that hit and miss the stored tags. A priority error among flush, restore and rename shows in the cycle after the collision, on lookups of the registers that were involved.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_RESTORE = 2'd1,
    MODE_FLUSH   = 2'd2
  } rmt_mode_e;

  function automatic rmt_mode_e pick_mode(input logic flush, input logic restore);
    if (flush)        return MODE_FLUSH;
    else if (restore) return MODE_RESTORE;
    else              return MODE_NORMAL;
  endfunction

endpackage

// File: rtl/rmt_live_table.sv
module rmt_live_table
  import rmt_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int REG_W    = 5,
  parameter int TAG_W    = 6
) (
  input  logic                                clk,
  input  logic                                rst,
  input  rmt_mode_e                           mode,
  input  logic [NUM_ARCH-1:0]                 rcv_vld,
  input  logic [NUM_ARCH-1:0][TAG_W-1:0]      rcv_tags,
  input  logic                                ren_en,
  input  logic [REG_W-1:0]                    ren_reg,
  input  logic [TAG_W-1:0]                    ren_tag,
  input  logic                                ret_en,
  input  logic [REG_W-1:0]                    ret_reg,
  input  logic [TAG_W-1:0]                    ret_tag,
  output logic [NUM_ARCH-1:0]                 cur_vld,
  output logic [NUM_ARCH-1:0][TAG_W-1:0]      cur_tags,
  output logic [NUM_ARCH-1:0]                 nxt_vld,
  output logic [NUM_ARCH-1:0][TAG_W-1:0]      nxt_tags
);

  always_comb begin
    for (int r = 0; r < NUM_ARCH; r++) begin
      nxt_vld[r]  = (mode == MODE_RESTORE) ? rcv_vld[r]  : cur_vld[r];
      nxt_tags[r] = (mode == MODE_RESTORE) ? rcv_tags[r] : cur_tags[r];
      if (ret_en && (ret_reg == REG_W'(r)) && (nxt_tags[r] == ret_tag))
        nxt_vld[r] = 1'b0;
      if ((mode == MODE_NORMAL) && ren_en && (ren_reg == REG_W'(r))) begin
        nxt_vld[r]  = 1'b1;
        nxt_tags[r] = ren_tag;
      end
      if (mode == MODE_FLUSH)
        nxt_vld[r] = 1'b0;
      if (r == 0) begin
        nxt_vld[r]  = 1'b0;
        nxt_tags[r] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_vld  <= '0;
      cur_tags <= '0;
    end else begin
      cur_vld  <= nxt_vld;
      cur_tags <= nxt_tags;
    end
  end

endmodule

// File: rtl/rmt_ckpt_slot.sv
module rmt_ckpt_slot #(
  parameter int NUM_ARCH = 32,
  parameter int REG_W    = 5,
  parameter int TAG_W    = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           take,
  input  logic                           flush,
  input  logic                           ret_en,
  input  logic [REG_W-1:0]               ret_reg,
  input  logic [TAG_W-1:0]               ret_tag,
  input  logic [NUM_ARCH-1:0]            ld_vld,
  input  logic [NUM_ARCH-1:0][TAG_W-1:0] ld_tags,
  output logic [NUM_ARCH-1:0]            vld,
  output logic [NUM_ARCH-1:0][TAG_W-1:0] tags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      tags <= '0;
    end else if (take) begin
      vld  <= ld_vld;
      tags <= ld_tags;
    end else if (flush) begin
      vld <= '0;
    end else begin
      for (int r = 0; r < NUM_ARCH; r++)
        if (ret_en && (ret_reg == REG_W'(r)) && (tags[r] == ret_tag))
          vld[r] <= 1'b0;
    end
  end

endmodule

// File: rtl/rmt_read_port.sv
module rmt_read_port #(
  parameter int NUM_ARCH = 32,
  parameter int REG_W    = 5,
  parameter int TAG_W    = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [REG_W-1:0]               rd_reg,
  input  logic [NUM_ARCH-1:0]            cur_vld,
  input  logic [NUM_ARCH-1:0][TAG_W-1:0] cur_tags,
  output logic                           hit,
  output logic [TAG_W-1:0]               tag
);

  logic mapped;
  assign mapped = (rd_reg != '0) && cur_vld[rd_reg];

  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
      tag <= '0;
    end else begin
      hit <= mapped;
      tag <= mapped ? cur_tags[rd_reg] : '0;
    end
  end

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rmt_pkg::*;
#(
  parameter  int NUM_ARCH  = 32,
  parameter  int ROB_DEPTH = 64,
  parameter  int NUM_CKPT  = 4,
  localparam int REG_W     = $clog2(NUM_ARCH),
  localparam int TAG_W     = $clog2(ROB_DEPTH),
  localparam int SLOT_W    = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  lk_a_reg,
  output logic              lk_a_hit,
  output logic [TAG_W-1:0]  lk_a_tag,
  input  logic [REG_W-1:0]  lk_b_reg,
  output logic              lk_b_hit,
  output logic [TAG_W-1:0]  lk_b_tag,
  input  logic              ren_en,
  input  logic [REG_W-1:0]  ren_reg,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              ret_en,
  input  logic [REG_W-1:0]  ret_reg,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic              snap_en,
  input  logic [SLOT_W-1:0] snap_slot,
  input  logic              rcv_en,
  input  logic [SLOT_W-1:0] rcv_slot,
  input  logic              flush_en
);

  rmt_mode_e mode;
  assign mode = pick_mode(flush_en, rcv_en);

  logic [NUM_ARCH-1:0]                           cur_vld, nxt_vld;
  logic [NUM_ARCH-1:0][TAG_W-1:0]                cur_tags, nxt_tags;
  logic [NUM_CKPT-1:0][NUM_ARCH-1:0]             ck_vld;
  logic [NUM_CKPT-1:0][NUM_ARCH-1:0][TAG_W-1:0]  ck_tags;
  logic [NUM_ARCH-1:0]                           rcv_vld;
  logic [NUM_ARCH-1:0][TAG_W-1:0]                rcv_tags;

  assign rcv_vld  = ck_vld[rcv_slot];
  assign rcv_tags = ck_tags[rcv_slot];

  rmt_live_table #(.NUM_ARCH(NUM_ARCH), .REG_W(REG_W), .TAG_W(TAG_W)) u_live (
    .clk(clk), .rst(rst), .mode(mode),
    .rcv_vld(rcv_vld), .rcv_tags(rcv_tags),
    .ren_en(ren_en), .ren_reg(ren_reg), .ren_tag(ren_tag),
    .ret_en(ret_en), .ret_reg(ret_reg), .ret_tag(ret_tag),
    .cur_vld(cur_vld), .cur_tags(cur_tags),
    .nxt_vld(nxt_vld), .nxt_tags(nxt_tags)
  );

  for (genvar s = 0; s < NUM_CKPT; s++) begin : g_ckpt
    rmt_ckpt_slot #(.NUM_ARCH(NUM_ARCH), .REG_W(REG_W), .TAG_W(TAG_W)) u_slot (
      .clk(clk), .rst(rst),
      .take(snap_en && (snap_slot == SLOT_W'(s))),
      .flush(flush_en),
      .ret_en(ret_en), .ret_reg(ret_reg), .ret_tag(ret_tag),
      .ld_vld(nxt_vld), .ld_tags(nxt_tags),
      .vld(ck_vld[s]), .tags(ck_tags[s])
    );
  end

  rmt_read_port #(.NUM_ARCH(NUM_ARCH), .REG_W(REG_W), .TAG_W(TAG_W)) u_rd_a (
    .clk(clk), .rst(rst), .rd_reg(lk_a_reg),
    .cur_vld(cur_vld), .cur_tags(cur_tags),
    .hit(lk_a_hit), .tag(lk_a_tag)
  );

  rmt_read_port #(.NUM_ARCH(NUM_ARCH), .REG_W(REG_W), .TAG_W(TAG_W)) u_rd_b (
    .clk(clk), .rst(rst), .rd_reg(lk_b_reg),
    .cur_vld(cur_vld), .cur_tags(cur_tags),
    .hit(lk_b_hit), .tag(lk_b_tag)
  );

endmodule

// File: rtl/rmt_checker.sv
module rmt_checker #(
  parameter int REG_W = 5,
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] lk_a_reg,
  input logic             lk_a_hit,
  input logic [TAG_W-1:0] lk_a_tag,
  input logic             lk_b_hit,
  input logic             ren_en,
  input logic [REG_W-1:0] ren_reg,
  input logic [TAG_W-1:0] ren_tag,
  input logic             rcv_en,
  input logic             flush_en
);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $fell(rst) |-> (!lk_a_hit && !lk_b_hit));

  // R2
  miss_zero_tag_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_a_hit |-> (lk_a_tag == '0));

  // R6
  zero_reg_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_a_reg == '0) |=> !lk_a_hit);

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush_en |=> ##1 (!lk_a_hit && !lk_b_hit));

  // R3
  rename_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ((age == 2'd3) && $past(ren_en, 2) && ($past(ren_reg, 2) != '0) &&
     !$past(flush_en, 2) && !$past(rcv_en, 2) &&
     ($past(lk_a_reg) == $past(ren_reg, 2)))
    |-> (lk_a_hit && (lk_a_tag == $past(ren_tag, 2))));

endmodule

bind rename_map_table rmt_checker #(.REG_W(REG_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .lk_a_reg(lk_a_reg), .lk_a_hit(lk_a_hit),
  .lk_a_tag(lk_a_tag), .lk_b_hit(lk_b_hit), .ren_en(ren_en),
  .ren_reg(ren_reg), .ren_tag(ren_tag), .rcv_en(rcv_en), .flush_en(flush_en)
);

// File: tb/sim_rename_map_table.sv
module sim_rename_map_table;

  localparam int NA = 32;
  localparam int NC = 4;
  localparam int RW = 5;
  localparam int TW = 6;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [RW-1:0] lk_a_reg = '0, lk_b_reg = '0, ren_reg = '0, ret_reg = '0;
  logic [TW-1:0] ren_tag = '0, ret_tag = '0;
  logic          ren_en = 0, ret_en = 0, snap_en = 0, rcv_en = 0, flush_en = 0;
  logic [SW-1:0] snap_slot = '0, rcv_slot = '0;
  logic          lk_a_hit, lk_b_hit;
  logic [TW-1:0] lk_a_tag, lk_b_tag;

  rename_map_table #(.NUM_ARCH(NA), .ROB_DEPTH(64), .NUM_CKPT(NC)) u0 (
    .clk(clk), .rst(rst),
    .lk_a_reg(lk_a_reg), .lk_a_hit(lk_a_hit), .lk_a_tag(lk_a_tag),
    .lk_b_reg(lk_b_reg), .lk_b_hit(lk_b_hit), .lk_b_tag(lk_b_tag),
    .ren_en(ren_en), .ren_reg(ren_reg), .ren_tag(ren_tag),
    .ret_en(ret_en), .ret_reg(ret_reg), .ret_tag(ret_tag),
    .snap_en(snap_en), .snap_slot(snap_slot),
    .rcv_en(rcv_en), .rcv_slot(rcv_slot), .flush_en(flush_en)
  );

  bit          mv [NA];
  int          mt [NA];
  bit          cv [NC][NA];
  int          ct [NC][NA];
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  function automatic int exp_tag(input int r);
    return (r != 0 && mv[r]) ? mt[r] : 0;
  endfunction

  task automatic check(input string req, input string port, input bit hit,
                       input int tag, input bit ehit, input int etag);
    n_run++;
    if (hit !== ehit || tag !== etag) begin
      n_fail++;
      $display("FAIL %s port %s: hit=%0d tag=%0d expected hit=%0d tag=%0d",
               req, port, hit, tag, ehit, etag);
    end
  endtask

  // Model update follows R3..R10; called at a negedge with inputs set.
  task automatic tick(input string req);
    bit nv [NA];
    int nt [NA];
    bit eah, ebh;
    int eat, ebt;
    eah = (lk_a_reg != 0) && mv[lk_a_reg]; eat = exp_tag(int'(lk_a_reg));
    ebh = (lk_b_reg != 0) && mv[lk_b_reg]; ebt = exp_tag(int'(lk_b_reg));
    for (int r = 0; r < NA; r++) begin
      nv[r] = rcv_en ? cv[rcv_slot][r] : mv[r];
      nt[r] = rcv_en ? ct[rcv_slot][r] : mt[r];
      if (ret_en && ret_reg == r && nt[r] == ret_tag) nv[r] = 0;
      if (!flush_en && !rcv_en && ren_en && ren_reg == r) begin
        nv[r] = 1; nt[r] = ren_tag;
      end
      if (flush_en) nv[r] = 0;
      if (r == 0) begin nv[r] = 0; nt[r] = 0; end
    end
    for (int s = 0; s < NC; s++)
      for (int r = 0; r < NA; r++) begin
        if (snap_en && snap_slot == s) begin cv[s][r] = nv[r]; ct[s][r] = nt[r]; end
        else if (flush_en) cv[s][r] = 0;
        else if (ret_en && ret_reg == r && ct[s][r] == ret_tag) cv[s][r] = 0;
      end
    for (int r = 0; r < NA; r++) begin mv[r] = nv[r]; mt[r] = nt[r]; end
    @(negedge clk);
    check(req, "A", lk_a_hit, int'(lk_a_tag), eah, eat);
    check(req, "B", lk_b_hit, int'(lk_b_tag), ebh, ebt);
    ren_en = 0; ret_en = 0; snap_en = 0; rcv_en = 0; flush_en = 0;
  endtask

  task automatic look(input int a, input int b);
    lk_a_reg = RW'(a); lk_b_reg = RW'(b);
  endtask

  task automatic ren(input int r, input int t);
    ren_en = 1; ren_reg = RW'(r); ren_tag = TW'(t);
  endtask

  task automatic ret(input int r, input int t);
    ret_en = 1; ret_reg = RW'(r); ret_tag = TW'(t);
  endtask

  initial begin
    for (int r = 0; r < NA; r++) begin mv[r] = 0; mt[r] = 0; end
    for (int s = 0; s < NC; s++)
      for (int r = 0; r < NA; r++) begin cv[s][r] = 0; ct[s][r] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: first cycle after reset
    look(5, 0); tick("R1");
    // R3 / R4: rename r6 and look it up in the same cycle, then the next
    look(6, 7); ren(6, 10); tick("R4");
    look(6, 7); tick("R3");
    // R4: source equals destination reads the older producer
    look(6, 6); ren(6, 11); tick("R4");
    look(6, 0); tick("R3");
    // R6: rename of register 0 ignored
    look(0, 1); ren(0, 3); tick("R6");
    look(0, 6); tick("R6");
    // R5: stale retire leaves mapping, matching retire clears it
    look(6, 6); ret(6, 10); tick("R5");
    look(6, 6); ret(6, 11); tick("R5");
    look(6, 6); tick("R5");
    // R8 / R9: snapshot includes same-cycle rename; restore beats rename
    look(2, 3); ren(2, 20); snap_en = 1; snap_slot = 2'd1; tick("R8");
    look(2, 3); ren(2, 21); tick("R8");
    look(2, 3); ren(3, 30); rcv_en = 1; rcv_slot = 2'd1; tick("R9");
    look(2, 3); tick("R9");
    // R10: retire scrubs snapshot and applies to restored map
    look(4, 2); ren(4, 40); snap_en = 1; snap_slot = 2'd2; tick("R10");
    look(4, 2); ret(4, 40); tick("R10");
    look(4, 2); rcv_en = 1; rcv_slot = 2'd2; tick("R10");
    look(4, 2); tick("R10");
    look(9, 2); ren(9, 50); snap_en = 1; snap_slot = 2'd3; tick("R10");
    look(9, 2); ren(9, 51); tick("R10");
    look(9, 2); ret(9, 50); rcv_en = 1; rcv_slot = 2'd3; tick("R10");
    look(9, 2); tick("R10");
    // R7: flush overrides everything and empties snapshots
    look(9, 2); ren(12, 5); snap_en = 1; snap_slot = 2'd0; tick("R7");
    look(12, 2); ren(13, 6); rcv_en = 1; rcv_slot = 2'd0; flush_en = 1; tick("R7");
    look(12, 13); tick("R7");
    look(12, 13); rcv_en = 1; rcv_slot = 2'd0; tick("R7");
    look(12, 13); tick("R7");
    // R2: constrained random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int ra, rb;
      ra = int'($urandom_range(NA - 1)); rb = int'($urandom_range(NA - 1));
      look(ra, rb);
      if ($urandom_range(99) < 60) ren(int'($urandom_range(NA - 1)), int'($urandom_range(63)));
      if ($urandom_range(99) < 35) begin
        int rr;
        rr = int'($urandom_range(NA - 1));
        ret(rr, ($urandom_range(3) != 0) ? mt[rr] : int'($urandom_range(63)));
      end
      if ($urandom_range(99) < 15) begin snap_en = 1; snap_slot = SW'($urandom_range(NC - 1)); end
      if ($urandom_range(99) < 6)  begin rcv_en = 1; rcv_slot = SW'($urandom_range(NC - 1)); end
      if ($urandom_range(199) < 2) flush_en = 1;
      tick("R2");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule